// File: doc/BRIEF.md
# Scaler Phase Table Sequencer

The sequencer produces, for one axis of an image resizer, the list of per-phase filter settings that a coefficient lookup table is loaded with. A command carries the ratio of output size to input size as `num:den`. The block answers with a stream of words on a valid/ready interface. The first word is a table-start marker. After it come exactly `num` phase entries. Each entry holds a bilinear-style weight in units of 1/512 of the nearer source pixel, a count of source pixels to step past after that phase, and a flag that marks downscaling.

The ratio picks one of three walks through the phases:
- **Downscale** (`num < den`) folds a running position back into a window twice the size of `num`.
- **Integer upscale** (`num` a multiple of `den`) repeats each source pixel at full weight.
- **Fractional upscale** steps a position by `den` and wraps it at `num`.

The divisions and remainders the walks need come from a small serial divider. Each entry is offered only once its quotients are complete. An identity ratio, or a zero in either term, starts no table.

Top module: `scl_phase_seq`

## Requirements
- R1: After a command that starts a table is accepted, the first output word is all ones (the table-start marker) and no entry precedes it.
- R2: A table holds exactly `num` entries after the marker. No further word is offered afterwards, and `cmd_ready` is high again once the last entry is taken.
- R3: Downscale mode (`num < den`), entry fields are computed as follows:
  - The running position starts at `den`. For each entry, the position becomes `num + ((pos - num) mod 2num)`.
  - The weight is `512 - floor(512*(pos - num)/(2num))`.
  - Then `2den` is added to the position, and the advance is `floor((pos - num)/(2num))`.
  - The down flag is 1.
- R4: When `num > den` and `num` is a multiple of `den`, every entry has weight 512 and down flag 0. The advance is 1 on the last entry only and 0 on the others.
- R5: In the other upscale ratios, entry fields are computed as follows:
  - A position starts at 0. Each entry has weight `512 - floor(512*pos/num)` and down flag 0.
  - Then `den` is added to the position. The advance is 1 if the position has reached `num`, and in that case `num` is subtracted; otherwise the advance is 0.
- R6: A command with `num == den`, `num == 0` or `den == 0` is accepted and produces no output word. `cmd_ready` returns high without any table.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` keeps its value on the next cycle.
- R8: `cmd_ready` is high only while no table is in progress, and it is high after reset. A command held valid during a table is taken only after that table's last entry. Its marker then follows that entry.
- R9: Entry word layout (17 bits at default parameters):
  - Bits [16:7] carry the weight.
  - Bits [6:1] carry the advance.
  - Bit 0 carries the down flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A ratio command is offered |
| cmd_ready | output | 1 | Sequencer idle and takes the command |
| cmd_num | input | NUM_W | Ratio numerator (output size term), up to 31 |
| cmd_den | input | DEN_W | Ratio denominator (input size term) |
| out_valid | output | 1 | Marker or entry word offered |
| out_ready | input | 1 | Consumer takes the offered word |
| out_word | output | FRAC_W+DEN_W+3 | Marker (all ones) or entry {weight, advance, down} |

## Verification
Two events can meet in one cycle: the handshake of a table's last entry, and a new command waiting at the input. The bench holds a second command valid from the moment the first is taken. It then checks three things: `cmd_ready` never rises while a word is on offer, the first table ends after exactly `num` entries, and the second table's marker is the next word. A second clash, a divider result landing while the consumer stalls, is provoked with a periodic `out_ready` gap and judged by the hold rule of R7 and by the exact entry values.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_PREP,
        ST_WGT,
        ST_OFS,
        ST_EMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_DOWN,
        MD_INTUP,
        MD_FRACUP,
        MD_SKIP
    } scl_mode_e;

endpackage

// File: rtl/scl_div.sv
// Restoring serial divider: one quotient bit per cycle, done pulses once.
module scl_div #(
    parameter int DVD_W = 15,
    parameter int DVS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quot_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DVS_W-1:0] dvs;
        logic [DVS_W-1:0] rem;
        logic [DVD_W-1:0] quo;
    } div_reg_t;

    div_reg_t q, d;
    logic [DVS_W:0] trial;
    logic [DVS_W:0] dvs_ext;
    logic           ge;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial   = {q.rem, q.quo[DVD_W-1]};
        dvs_ext = {1'b0, q.dvs};
        ge      = (trial >= dvs_ext);
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.dvs  = divisor_i;
            d.rem  = '0;
            d.quo  = dividend_i;
        end else if (q.busy) begin
            d.quo = {q.quo[DVD_W-2:0], ge};
            d.rem = ge ? DVS_W'(trial - dvs_ext) : trial[DVS_W-1:0];
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(DVD_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quo;
    assign rem_o  = q.rem;

    // R3: a completed remainder is always below the divisor
    p_div_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < q.dvs));

    // R3: the divider is never started with a zero divisor
    p_div_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (divisor_i != '0));

endmodule

// File: rtl/scl_mode_dec.sv
// Classifies a ratio into one of the sequencing modes.
module scl_mode_dec
    import scl_pkg::*;
#(
    parameter int NUM_W = 5,
    parameter int DEN_W = 5
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output scl_mode_e        mode_o
);
    localparam int CW = (NUM_W > DEN_W) ? NUM_W : DEN_W;

    logic [CW-1:0] n_e;
    logic [CW-1:0] d_e;

    always_comb begin
        n_e = CW'(num_i);
        d_e = CW'(den_i);
        if (n_e == '0 || d_e == '0 || n_e == d_e) begin
            mode_o = MD_SKIP;
        end else if (n_e < d_e) begin
            mode_o = MD_DOWN;
        end else if ((n_e % d_e) == '0) begin
            mode_o = MD_INTUP;
        end else begin
            mode_o = MD_FRACUP;
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
// Emits a table-start marker followed by num phase entries for one axis.
module scl_phase_seq
    import scl_pkg::*;
#(
    parameter int NUM_W  = 5,
    parameter int DEN_W  = 5,
    parameter int FRAC_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic [NUM_W-1:0]            cmd_num,
    input  logic [DEN_W-1:0]            cmd_den,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [FRAC_W+DEN_W+2:0]     out_word
);
    localparam int WT_W   = FRAC_W + 1;
    localparam int ADV_W  = DEN_W + 1;
    localparam int WORD_W = WT_W + ADV_W + 1;
    localparam int DVS_W  = NUM_W + 1;
    localparam int CW     = (NUM_W > DEN_W) ? NUM_W : DEN_W;
    localparam int OFS_W  = ((DVS_W > DEN_W + 1) ? DVS_W : DEN_W + 1) + 1;
    localparam int DVD_W  = (DVS_W + FRAC_W > OFS_W) ? DVS_W + FRAC_W : OFS_W;
    localparam logic [WT_W-1:0] ONE = WT_W'(1) << FRAC_W;

    typedef struct packed {
        seq_state_e       st;
        scl_mode_e        mode;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] idx;
        logic [NUM_W-1:0] acc;
        logic [DVS_W-1:0] r;
        logic [WT_W-1:0]  wt;
        logic [ADV_W-1:0] adv;
    } seq_reg_t;

    seq_reg_t q, d;

    scl_mode_e        dec_mode;
    logic             div_start;
    logic [DVD_W-1:0] div_dvd;
    logic [DVS_W-1:0] div_dvs;
    logic             div_done;
    logic [DVD_W-1:0] div_quot;
    logic [DVS_W-1:0] div_rem;
    logic             div_hi_unused;

    logic [DVS_W-1:0] two_num;
    logic [DVS_W-1:0] num_ext;
    logic [CW:0]      frac_sum;
    logic             at_last;
    logic             next_last;

    scl_mode_dec #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_mode_dec (
        .num_i  (cmd_num),
        .den_i  (cmd_den),
        .mode_o (dec_mode)
    );

    scl_div #(
        .DVD_W (DVD_W),
        .DVS_W (DVS_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    assign div_hi_unused = ^div_quot[DVD_W-1:WT_W];

    always_comb begin
        d         = q;
        div_start = 1'b0;
        div_dvd   = '0;
        div_dvs   = '0;
        two_num   = {q.num, 1'b0};
        num_ext   = {1'b0, q.num};
        frac_sum  = (CW + 1)'(q.acc) + (CW + 1)'(q.den);
        at_last   = ({1'b0, q.idx} == ({1'b0, q.num} - (NUM_W + 1)'(1)));
        next_last = (({1'b0, q.idx} + (NUM_W + 1)'(1)) ==
                     ({1'b0, q.num} - (NUM_W + 1)'(1)));

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.num  = cmd_num;
                    d.den  = cmd_den;
                    d.mode = dec_mode;
                    d.idx  = '0;
                    d.acc  = '0;
                    d.r    = '0;
                    d.st   = (dec_mode == MD_SKIP) ? ST_IDLE : ST_MARK;
                end
            end
            ST_MARK: begin
                if (out_ready) begin
                    unique case (q.mode)
                        MD_DOWN: begin
                            // initial fold of (den - num) into the 2*num window
                            div_start = 1'b1;
                            div_dvd   = DVD_W'(q.den) - DVD_W'(q.num);
                            div_dvs   = two_num;
                            d.st      = ST_PREP;
                        end
                        MD_FRACUP: begin
                            div_start = 1'b1;
                            div_dvd   = DVD_W'(q.acc) << FRAC_W;
                            div_dvs   = num_ext;
                            d.st      = ST_WGT;
                        end
                        MD_INTUP: begin
                            d.wt  = ONE;
                            d.adv = ADV_W'(q.num == NUM_W'(1));
                            d.st  = ST_EMIT;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
            ST_PREP: begin
                if (div_done) begin
                    d.r       = div_rem;
                    div_start = 1'b1;
                    div_dvd   = DVD_W'(div_rem) << FRAC_W;
                    div_dvs   = two_num;
                    d.st      = ST_WGT;
                end
            end
            ST_WGT: begin
                if (div_done) begin
                    d.wt = ONE - div_quot[WT_W-1:0];
                    if (q.mode == MD_DOWN) begin
                        div_start = 1'b1;
                        div_dvd   = DVD_W'(q.r) + (DVD_W'(q.den) << 1);
                        div_dvs   = two_num;
                        d.st      = ST_OFS;
                    end else begin
                        if (frac_sum >= (CW + 1)'(q.num)) begin
                            d.adv = ADV_W'(1);
                            d.acc = NUM_W'(frac_sum - (CW + 1)'(q.num));
                        end else begin
                            d.adv = '0;
                            d.acc = NUM_W'(frac_sum);
                        end
                        d.st = ST_EMIT;
                    end
                end
            end
            ST_OFS: begin
                if (div_done) begin
                    d.adv = div_quot[ADV_W-1:0];
                    d.r   = div_rem;
                    d.st  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (at_last) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        unique case (q.mode)
                            MD_DOWN: begin
                                div_start = 1'b1;
                                div_dvd   = DVD_W'(q.r) << FRAC_W;
                                div_dvs   = two_num;
                                d.st      = ST_WGT;
                            end
                            MD_FRACUP: begin
                                div_start = 1'b1;
                                div_dvd   = DVD_W'(q.acc) << FRAC_W;
                                div_dvs   = num_ext;
                                d.st      = ST_WGT;
                            end
                            default: begin
                                d.wt  = ONE;
                                d.adv = ADV_W'(next_last);
                            end
                        endcase
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.mode <= MD_SKIP;
            q.num  <= '0;
            q.den  <= '0;
            q.idx  <= '0;
            q.acc  <= '0;
            q.r    <= '0;
            q.wt   <= '0;
            q.adv  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign out_valid = (q.st == ST_MARK) || (q.st == ST_EMIT);
    assign out_word  = (q.st == ST_MARK) ? {WORD_W{1'b1}}
                                         : {q.wt, q.adv, (q.mode == MD_DOWN)};

    // R7: an offered word is held while the consumer stalls
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R2: the entry index never passes the table length
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.idx < q.num));

    // R4: integer upscale entries are always full weight
    p_int_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EMIT && q.mode == MD_INTUP) |-> (out_word[WORD_W-1 -: WT_W] == ONE));

    // R5: fractional position stays below num
    p_frac_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.mode == MD_FRACUP) |-> (q.acc < q.num));

    // R3: downscale residue stays inside its 2*num window
    p_down_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EMIT && q.mode == MD_DOWN) |-> (q.r < two_num));

    // R3: entry weights never exceed one whole pixel
    p_weight_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EMIT) |-> (q.wt <= ONE));

    // R6: an identity or empty ratio leaves the sequencer ready
    p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && dec_mode == MD_SKIP) |=> (cmd_ready && !out_valid));

endmodule

// File: tb/scl_phase_seq_bench.sv
module scl_phase_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [4:0]        cmd_num = '0;
    logic [4:0]        cmd_den = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [WORD_W-1:0] out_word;

    int errors = 0;
    int checks = 0;

    logic [WORD_W-1:0] exp_w [0:79];
    bit                exp_mk [0:79];
    int                exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_phase_seq u_scl_phase_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_num   (cmd_num),
        .cmd_den   (cmd_den),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference model written from R3, R4, R5 and the R9 layout
    task automatic add_table(input int n, input int dd);
        int acc;
        int w;
        int off;
        bit dn;
        exp_w[exp_n]  = '1;
        exp_mk[exp_n] = 1'b1;
        exp_n++;
        acc = (n < dd) ? dd : 0;
        for (int i = 0; i < n; i++) begin
            if (n < dd) begin
                acc = n + ((acc - n) % (2 * n));
                w   = 512 - (512 * (acc - n)) / (2 * n);
                acc = acc + 2 * dd;
                off = (acc - n) / (2 * n);
                dn  = 1'b1;
            end else if ((n % dd) == 0) begin
                w   = 512;
                off = (i == n - 1) ? 1 : 0;
                dn  = 1'b0;
            end else begin
                w   = 512 - (512 * acc) / n;
                acc = acc + dd;
                off = (acc >= n) ? 1 : 0;
                if (off == 1) acc = acc - n;
                dn  = 1'b0;
            end
            exp_w[exp_n]  = {w[9:0], off[5:0], dn};
            exp_mk[exp_n] = 1'b0;
            exp_n++;
        end
    endtask

    task automatic send_cmd(input int n, input int dd);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_num   = n[4:0];
        cmd_den   = dd[4:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic collect(input bit stall, input string tag,
                           output int hold_err, output int busy_err);
        int idx = 0;
        int cyc = 0;
        bit prev_stall = 1'b0;
        logic [WORD_W-1:0] prev_word = '0;
        hold_err = 0;
        busy_err = 0;
        while (idx < exp_n && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (prev_stall && (!out_valid || out_word != prev_word)) hold_err++;
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (out_valid && cmd_ready) busy_err++;
            prev_stall = out_valid && !out_ready;
            prev_word  = out_word;
            if (out_valid && out_ready) begin
                chk(out_word == exp_w[idx], exp_mk[idx] ? "R1 marker" : tag,
                    32'(out_word), 32'(exp_w[idx]));
                idx++;
            end
        end
        chk(idx == exp_n, "R2 word count", 32'(idx), 32'(exp_n));
    endtask

    task automatic drain_idle(input string tag);
        bit seen = 1'b0;
        out_ready = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(!seen, tag, 32'(seen), 32'd0);
        chk(cmd_ready, tag, 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R8 ready after reset", 32'(cmd_ready), 32'd1);
        chk(out_valid == 1'b0, "R2 idle after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_table(input int n, input int dd, input bit stall, input string tag);
        int he;
        int be;
        exp_n = 0;
        add_table(n, dd);
        fork
            send_cmd(n, dd);
            collect(stall, tag, he, be);
        join
        if (stall) chk(he == 0, "R7 hold under stall", 32'(he), 32'd0);
        drain_idle("R2 no extra words");
    endtask

    task automatic t_back_to_back(input int na, input int da, input int nb, input int db);
        int he;
        int be;
        exp_n = 0;
        add_table(na, da);
        add_table(nb, db);
        fork
            begin
                send_cmd(na, da);
                send_cmd(nb, db);
            end
            collect(1'b0, "R8 queued table entry", he, be);
        join
        chk(be == 0, "R8 ready while busy", 32'(be), 32'd0);
        drain_idle("R2 no extra words after pair");
    endtask

    task automatic t_bypass(input int n, input int dd);
        send_cmd(n, dd);
        drain_idle("R6 bypass ratio");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table(3, 5, 1'b0, "R3 downscale 3:5");
        t_table(1, 31, 1'b0, "R3 downscale 1:31");
        t_table(30, 31, 1'b0, "R3 downscale 30:31");
        t_table(4, 1, 1'b0, "R4 integer 4:1");
        t_table(31, 1, 1'b0, "R4 integer 31:1");
        t_table(6, 2, 1'b0, "R4 integer 6:2");
        t_table(5, 3, 1'b0, "R5 fractional 5:3");
        t_table(31, 30, 1'b0, "R5 fractional 31:30");
        t_table(7, 4, 1'b1, "R5 fractional 7:4 stalled");
        t_table(11, 17, 1'b1, "R3 downscale 11:17 stalled");
        t_bypass(1, 1);
        t_bypass(7, 7);
        t_bypass(0, 5);
        t_bypass(5, 0);
        t_back_to_back(9, 4, 2, 7);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule